// File: doc/BRIEF.md
# Timer Stage-0 Prescaler

This block divides the processor's executed-cycle stream down to the tick that advances the first-stage timer counters. The bus sequencer raises a one-clock strobe for every processor cycle that completes. The block counts these strobes, not clock edges, so a cycle stretched by wait states still counts as one. When a programmable number of strobes has been counted, the block emits a one-clock tick.

The period comes from two 2-bit speed codes in the 8-bit configuration byte that also sets memory timing. The internal speed code sits in bits 7:6 and the external speed code sits in bits 5:4. The period is `(1 << bits[7:6]) + (2 << bits[5:4])`, which gives a value from 3 to 24 strobes. The configuration is sampled on every strobe, so a change takes effect at once. A synchronous active-high reset returns the count to its start.

Top module: `tmr_stage0_prescaler`

## Requirements
- R1: With continuous strobes, the number of strobes from one tick to the next equals `(1 << cfg[7:6]) + (2 << cfg[5:4])` for every code pair.
- R2: With cfg[7:6] = 0, the period is 3, 5, 9 and 17 strobes for cfg[5:4] = 0, 1, 2 and 3.
- R3: With cfg[7:6] = 3, the period is 10, 12, 16 and 24 strobes for cfg[5:4] = 0, 1, 2 and 3. 24 is the longest period.
- R4: The configuration value 0x0A gives a period of 3 strobes.
- R5: Only clocks with `cyc_en` high advance the count. Idle clocks between strobes neither advance it nor produce a tick, so the period is the same however far apart the strobes are.
- R6: `tick` is high for exactly one clock. That clock directly follows the clock in which the strobe completing a period was given.
- R7: If the configuration changes while the count is already at or past the new period minus one, the next strobe produces a tick and restarts the count.
- R8: While `rst` is high, `tick` is low on the following clock. After reset is released, the first tick comes after a full period of strobes.
- R9: Configuration bits 3:0 have no effect on the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | One-clock strobe per executed processor cycle |
| cfg | input | 8 | Configuration byte; bits 7:6 internal speed code, bits 5:4 external speed code |
| tick | output | 1 | Registered one-clock pulse that advances stage-1 timers |

## Verification
The hardest condition to reach from the ports is a count that already lies beyond the terminal value of a newly selected, shorter period (R7). In normal running the count never passes its terminal value, so the bench creates this case on purpose. It selects the 24-strobe period, issues a number of strobes chosen to exceed the shorter limit, switches to a short period and checks for a tick on the very next strobe. The random phase also changes the configuration at arbitrary counts while strobes arrive with random gaps. This covers both the shrinking and the growing direction, and every clock is compared against a reference model.

// File: rtl/stg0_pkg.sv
package stg0_pkg;
  localparam int CFG_W  = 8;
  localparam int SEL_W  = 2;
  localparam int CNT_W  = 5;
  localparam int INT_LSB = 6;
  localparam int EXT_LSB = 4;

  // Number of strobes per tick for a pair of speed codes.
  function automatic int unsigned strobes_per_tick(input logic [SEL_W-1:0] int_code,
                                                   input logic [SEL_W-1:0] ext_code);
    return (32'd1 << int_code) + (32'd2 << ext_code);
  endfunction
endpackage

// File: rtl/stg0_period_decode.sv
module stg0_period_decode
  import stg0_pkg::*;
#(
  parameter int P_CFG_W   = CFG_W,
  parameter int P_CNT_W   = CNT_W,
  parameter int P_INT_LSB = INT_LSB,
  parameter int P_EXT_LSB = EXT_LSB
) (
  input  logic [P_CFG_W-1:0] cfg,
  output logic [P_CNT_W-1:0] last_idx
);
  logic [SEL_W-1:0] int_code;
  logic [SEL_W-1:0] ext_code;
  int unsigned      span;

  always_comb begin
    int_code = cfg[P_INT_LSB +: SEL_W];
    ext_code = cfg[P_EXT_LSB +: SEL_W];
    span     = strobes_per_tick(int_code, ext_code);
    last_idx = P_CNT_W'(span - 32'd1);
  end
endmodule

// File: rtl/stg0_strobe_counter.sv
module stg0_strobe_counter #(
  parameter int P_CNT_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic [P_CNT_W-1:0] last_idx,
  output logic [P_CNT_W-1:0] cnt,
  output logic               wrap
);
  // At or beyond the terminal value: also covers a period shortened under a running count.
  assign wrap = (cnt >= last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (step) begin
      if (wrap) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/stg0_tick_reg.sv
module stg0_tick_reg (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic wrap,
  output logic tick
);
  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= step & wrap;
  end
endmodule

// File: rtl/tmr_stage0_prescaler.sv
module tmr_stage0_prescaler
  import stg0_pkg::*;
#(
  parameter int P_CFG_W   = CFG_W,
  parameter int P_CNT_W   = CNT_W,
  parameter int P_INT_LSB = INT_LSB,
  parameter int P_EXT_LSB = EXT_LSB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cyc_en,
  input  logic [P_CFG_W-1:0] cfg,
  output logic               tick
);
  logic [P_CNT_W-1:0] last_idx;
  logic [P_CNT_W-1:0] cnt_q;
  logic               wrap;

  stg0_period_decode #(
    .P_CFG_W  (P_CFG_W),
    .P_CNT_W  (P_CNT_W),
    .P_INT_LSB(P_INT_LSB),
    .P_EXT_LSB(P_EXT_LSB)
  ) u_decode (
    .cfg     (cfg),
    .last_idx(last_idx)
  );

  stg0_strobe_counter #(
    .P_CNT_W(P_CNT_W)
  ) u_counter (
    .clk     (clk),
    .rst     (rst),
    .step    (cyc_en),
    .last_idx(last_idx),
    .cnt     (cnt_q),
    .wrap    (wrap)
  );

  stg0_tick_reg u_tick (
    .clk (clk),
    .rst (rst),
    .step(cyc_en),
    .wrap(wrap),
    .tick(tick)
  );
endmodule

// File: rtl/stg0_prescaler_chk.sv
module stg0_prescaler_chk #(
  parameter int P_CFG_W = 8,
  parameter int P_CNT_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               cyc_en,
  input logic [P_CFG_W-1:0] cfg,
  input logic               tick,
  input logic [P_CNT_W-1:0] cnt
);
  logic [5:0] lim;
  assign lim = 6'((6'd1 << cfg[7:6]) + (6'd2 << cfg[5:4]) - 6'd1);

  // R8
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !tick);

  // R5
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst) !cyc_en |=> !tick);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) !cyc_en |=> $stable(cnt));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);

  // R7
  overrun_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && 6'(cnt) >= lim) |=> (tick && cnt == '0));

  // R1
  early_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && 6'(cnt) < lim) |=> !tick);

  // R3
  bound_chk: assert property (@(posedge clk) disable iff (rst) cnt < P_CNT_W'(24));
endmodule

bind tmr_stage0_prescaler stg0_prescaler_chk #(
  .P_CFG_W(P_CFG_W),
  .P_CNT_W(P_CNT_W)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .cyc_en(cyc_en),
  .cfg   (cfg),
  .tick  (tick),
  .cnt   (cnt_q)
);

// File: tb/tmr_stage0_prescaler_tb.sv
module tmr_stage0_prescaler_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_en = 1'b0;
  logic [7:0] cfg = 8'h0A;
  logic       tick;

  int n_checks = 0;
  int n_fail   = 0;
  int model_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_stage0_prescaler u_dut (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .cfg(cfg), .tick(tick)
  );

  function automatic int exp_period(input logic [7:0] c);
    return (1 << c[7:6]) + (2 << c[5:4]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: drive, let the edge pass, compare tick against the model.
  task automatic step(input logic en, input logic r, input string req);
    bit exp_tick;
    cyc_en = en;
    rst    = r;
    @(posedge clk);
    #1;
    if (r) begin
      exp_tick  = 0;
      model_cnt = 0;
    end else if (en) begin
      exp_tick = (model_cnt >= exp_period(cfg) - 1);
      model_cnt = exp_tick ? 0 : model_cnt + 1;
    end else begin
      exp_tick = 0;
    end
    check(tick === exp_tick, req, int'(tick), int'(exp_tick));
  endtask

  // Count strobes between two ticks with a fixed idle gap after each strobe.
  task automatic measure(input logic [7:0] c, input int gap, input string req);
    int n = 0;
    int first = -1;
    int got = -1;
    cfg = c;
    step(0, 1, "R8");
    for (int i = 0; i < 60; i++) begin
      step(1, 0, req);
      n++;
      if (tick) begin
        if (first < 0) first = n;
        else begin
          got = n - first;
          break;
        end
      end
      for (int g = 0; g < gap; g++) step(0, 0, "R5");
    end
    check(got == exp_period(c), req, got, exp_period(c));
    check(first == exp_period(c), "R8 first tick after reset", first, exp_period(c));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R8: reset state
    step(0, 1, "R8");
    step(1, 1, "R8");
    check(tick === 1'b0, "R8 reset", int'(tick), 0);

    // R4
    measure(8'h0A, 0, "R4");
    // R2
    for (int e = 0; e < 4; e++) measure({2'd0, 2'(e), 4'h0}, 0, "R2");
    // R3
    for (int e = 0; e < 4; e++) measure({2'd3, 2'(e), 4'h5}, 0, "R3");
    // R1: all code pairs
    for (int i = 0; i < 4; i++)
      for (int e = 0; e < 4; e++) measure({2'(i), 2'(e), 4'hA}, 0, "R1");
    // R5: gaps between strobes
    measure(8'h5A, 1, "R5");
    measure(8'hA0, 3, "R5");
    // R9: low nibble ignored
    measure(8'h60, 0, "R9");
    measure(8'h6F, 0, "R9");

    // R7: count beyond shorter period
    cfg = 8'hF0;
    step(0, 1, "R8");
    for (int i = 0; i < 20; i++) step(1, 0, "R7");
    cfg = 8'h0A;
    step(1, 0, "R7");
    check(tick === 1'b1, "R7 overrun tick", int'(tick), 1);
    step(1, 0, "R7");
    step(1, 0, "R7");
    step(1, 0, "R7");
    check(tick === 1'b1, "R7 restart period", int'(tick), 1);

    // R6: tick is one clock wide when strobes stop after it
    cfg = 8'h0A;
    step(0, 1, "R8");
    step(1, 0, "R6"); step(1, 0, "R6"); step(1, 0, "R6");
    check(tick === 1'b1, "R6 tick", int'(tick), 1);
    step(0, 0, "R6");
    check(tick === 1'b0, "R6 one clock", int'(tick), 0);

    // Random run with config changes and gaps, model compared each clock (R1 R5 R7)
    for (int i = 0; i < 20000; i++) begin
      if (($urandom % 64) == 0) cfg = 8'($urandom);
      if (($urandom % 500) == 0) step(0, 1, "R8");
      else step(1'($urandom % 3 != 0), 0, "R1 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule